// File: doc/BRIEF.md
# Shared-Channel Access Arbiter for a Serial Frame Bus

This block decides which of several communication controllers may use the shared D and C/I channels of a time-multiplexed serial frame. The decision is made once per frame, inside a single arbitration byte on the upstream data line. The line is open-drain, so the bus carries the wired-AND of all the devices that drive it. Bit 5 of that byte is the access status: 1 means free and 0 means occupied. Bits 2..0 carry a 3-bit contender address. Each frame, the block looks at the status bit. If the bus is free and a request is pending, it sends its programmed address most significant bit first. It drops out as soon as it sends a 1 and reads back a 0.

The frame timing logic around the block marks each frame with `frame_start`. It presents each bit of the arbitration byte with `bit_vld` and its position `bit_pos`, which counts down from 7 to 0. The block returns `line_out` for that bit in the same cycle, where 1 means released and 0 means pulled low. It samples the resolved line `line_in` on the clock edge that closes the bit. A win becomes `granted` at the next frame. While the block holds the bus, it pulls the status bit low in every frame. After it gives the bus up, it backs off until it has seen two frames in a row that show the bus free. No pin carries streaming data, so every port is a plain control or status pin and none has back-pressure.

Top module: `tic_arbiter`

## Requirements
- R1: After reset, `granted` is 0 and `line_out` is 1.
- R2: While `en` is 0, `line_out` stays 1 and `granted` is 0. Dropping `en` while the bus is held clears `granted` on the next clock.
- R3: The request is the OR of `sw_req` and `hdlc_req`. Either source alone can win the bus and keep holding it.
- R4: The block contends in a frame only if it samples `line_in` as 1 at `bit_pos`=5 of that frame. Position 5 is the access status, where 1 means free.
- R5: While contending, the block drives `my_addr[p]` at `bit_pos`=p for p in 2..0, most significant bit first. It drives 1 on every other bit and in every other cycle.
- R6: If the block sends a 1 and samples a 0 at an address bit, it drives 1 for the rest of the byte and does not win that frame. The lowest address among the contenders therefore wins.
- R7: If all three address bits read back as sent, `granted` rises at the next `frame_start`, provided the request is still active. In every frame the bus is held, `line_out` is 0 at `bit_pos`=5.
- R8: If the request is inactive at a `frame_start` while the bus is held, `granted` falls at that `frame_start`, and bit 5 is released to 1 in that frame.
- R9: After the bus is given up, the block does not contend until it has sampled bit 5 as 1 in two consecutive frames. A frame with bit 5 at 0 restarts this count. Contention is allowed again in the frame after the second free frame.
- R10: When no device drives the address field, the field resolves to 7 (bits 2..0 read 111).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Arbitration enable |
| sw_req | input | 1 | Software access request |
| hdlc_req | input | 1 | HDLC frame waiting to be sent in the D channel |
| my_addr | input | 3 | Programmed contender address |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| bit_vld | input | 1 | A bit of the arbitration byte is on the line this cycle |
| bit_pos | input | 3 | Position of that bit, counting down from 7 to 0 |
| line_in | input | 1 | Resolved (wired-AND) line value, sampled at the end of the bit |
| line_out | output | 1 | Open-drain drive: 0 pulls low, 1 releases |
| granted | output | 1 | The block holds the shared channels |

## Verification
The hardest state to reach from the ports is the back-off window after a release, and above all its restart when an occupied frame lands between two free ones. The bench gets there by holding the bus, dropping the request, and raising it again at once. Between the free frames it injects a frame in which an external device pulls bit 5 low. It then confirms that contention starts exactly one frame after the second consecutive free frame. Lost contention is produced by external address patterns that are lower than the programmed address at different bit positions.

// File: rtl/tic_pkg.sv
package tic_pkg;
  parameter int TIC_POS_W = 3;
  typedef logic [TIC_POS_W-1:0] tic_pos_t;
endpackage

// File: rtl/tic_backoff.sv
module tic_backoff #(
  parameter int FREE_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic status_vld,
  input  logic status_free,
  output logic ready
);
  localparam int CW = $clog2(FREE_FRAMES + 1);
  localparam logic [CW-1:0] FULL = CW'(FREE_FRAMES);

  logic [CW-1:0] free_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_cnt <= FULL;
    end else if (restart) begin
      free_cnt <= '0;
    end else if (status_vld && free_cnt != FULL) begin
      free_cnt <= status_free ? free_cnt + 1'b1 : '0;
    end
  end

  assign ready = (free_cnt == FULL);

  AST_BACKOFF_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !ready); // R9
  AST_BUSY_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_vld && !status_free && !ready) |=> (free_cnt == '0)); // R9
endmodule

// File: rtl/tic_contend.sv
module tic_contend
  import tic_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int STAT_POS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              go,
  input  logic              frame_start,
  input  logic              bit_vld,
  input  tic_pos_t          bit_pos,
  input  logic              line_in,
  input  logic [ADDR_W-1:0] my_addr,
  output logic              contending,
  output logic              addr_slot,
  output logic              addr_bit,
  output logic              won
);
  localparam tic_pos_t STAT = tic_pos_t'(STAT_POS);
  localparam tic_pos_t LAST = '0;

  logic at_status;
  logic lost_now;

  always_comb begin
    addr_slot = 1'b0;
    addr_bit  = 1'b1;
    for (int i = 0; i < ADDR_W; i++) begin
      if (bit_pos == tic_pos_t'(i)) begin
        addr_slot = bit_vld;
        addr_bit  = my_addr[i];
      end
    end
  end

  assign at_status = bit_vld && (bit_pos == STAT);
  assign lost_now  = contending && addr_slot && addr_bit && !line_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      contending <= 1'b0;
      won        <= 1'b0;
    end else if (!en || frame_start) begin
      contending <= 1'b0;
      won        <= 1'b0;
    end else if (at_status) begin
      contending <= go && line_in;
    end else if (contending && addr_slot) begin
      if (lost_now) begin
        contending <= 1'b0;
      end else if (bit_pos == LAST) begin
        contending <= 1'b0;
        won        <= 1'b1;
      end
    end
  end

  AST_BUSY_NO_CONTEND: assert property (@(posedge clk) disable iff (!rst_n)
    (at_status && !line_in) |=> !contending); // R4
  AST_LOSE_WITHDRAWS: assert property (@(posedge clk) disable iff (!rst_n)
    lost_now |=> (!contending && !won)); // R6
endmodule

// File: rtl/tic_arbiter.sv
module tic_arbiter
  import tic_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int STAT_POS    = 5,
  parameter int FREE_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sw_req,
  input  logic              hdlc_req,
  input  logic [ADDR_W-1:0] my_addr,
  input  logic              frame_start,
  input  logic              bit_vld,
  input  tic_pos_t          bit_pos,
  input  logic              line_in,
  output logic              line_out,
  output logic              granted
);
  localparam tic_pos_t STAT = tic_pos_t'(STAT_POS);

  logic req, hold, hold_nxt, ready, go;
  logic contending, addr_slot, addr_bit, won, at_status;

  assign req       = sw_req | hdlc_req;
  assign at_status = bit_vld && (bit_pos == STAT);
  assign go        = en && req && ready && !hold && !won;

  always_comb begin
    hold_nxt = hold;
    if (!en) begin
      hold_nxt = 1'b0;
    end else if (frame_start && (hold || won)) begin
      hold_nxt = req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold <= 1'b0;
    else        hold <= hold_nxt;
  end

  tic_backoff #(.FREE_FRAMES(FREE_FRAMES)) u_backoff (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (hold && !hold_nxt),
    .status_vld  (en && at_status),
    .status_free (line_in),
    .ready       (ready)
  );

  tic_contend #(.ADDR_W(ADDR_W), .STAT_POS(STAT_POS)) u_contend (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .go          (go),
    .frame_start (frame_start),
    .bit_vld     (bit_vld),
    .bit_pos     (bit_pos),
    .line_in     (line_in),
    .my_addr     (my_addr),
    .contending  (contending),
    .addr_slot   (addr_slot),
    .addr_bit    (addr_bit),
    .won         (won)
  );

  always_comb begin
    line_out = 1'b1;
    if (en && hold && at_status)           line_out = 1'b0;
    else if (en && contending && addr_slot) line_out = addr_bit;
  end

  assign granted = hold;

  AST_OFF_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !granted); // R2
  AST_GRANT_RISES_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(granted) |-> $past(frame_start && won)); // R7
  AST_GRANT_FALLS_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(granted) |-> $past(!en || (frame_start && !req))); // R8
  AST_HOLD_NO_CONTEND: assert property (@(posedge clk) disable iff (!rst_n)
    granted |-> !contending); // R7
endmodule

// File: tb/tb_tic_arbiter.sv
module tb_tic_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, sw_req = 1'b0, hdlc_req = 1'b0;
  logic [2:0] my_addr = 3'd2;
  logic frame_start = 1'b0, bit_vld = 1'b0;
  logic [2:0] bit_pos = 3'd0;
  logic [7:0] ext_byte = 8'hFF;
  logic line_in, line_out, granted;
  logic [7:0] cap;

  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  assign line_in = line_out & (bit_vld ? ext_byte[bit_pos] : 1'b1);

  tic_arbiter dut (
    .clk(clk), .rst_n(rst_n), .en(en), .sw_req(sw_req), .hdlc_req(hdlc_req),
    .my_addr(my_addr), .frame_start(frame_start), .bit_vld(bit_vld),
    .bit_pos(bit_pos), .line_in(line_in), .line_out(line_out), .granted(granted));

  // behavioural reference model
  int m_hold = 0, m_cont = 0, m_won = 0, m_free = 2;

  function automatic int exp_line();
    int p = int'(bit_pos);
    if (!en || !bit_vld) return 1;
    if (m_hold != 0 && p == 5) return 0;
    if (m_cont != 0 && p < 3) return int'(my_addr[p]);
    return 1;
  endfunction

  task automatic check(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", rq, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int req, line, p, ready_old;
    cyc++;
    if (!rst_n) begin
      m_hold = 0; m_cont = 0; m_won = 0; m_free = 2;
    end else begin
      req = (sw_req || hdlc_req) ? 1 : 0;
      p = int'(bit_pos);
      line = exp_line() & (bit_vld ? int'(ext_byte[p]) : 1);
      ready_old = (m_free >= 2) ? 1 : 0;
      if (!en) begin
        if (m_hold != 0) m_free = 0;
        m_hold = 0; m_cont = 0; m_won = 0;
      end else if (frame_start) begin
        if (m_hold != 0 && req == 0) begin m_hold = 0; m_free = 0; end
        else if (m_won != 0 && req != 0) m_hold = 1;
        m_cont = 0; m_won = 0;
      end else if (bit_vld && p == 5) begin
        m_cont = (line != 0 && req != 0 && ready_old != 0 && m_hold == 0 && m_won == 0) ? 1 : 0;
        if (m_free < 2) m_free = (line != 0) ? m_free + 1 : 0;
      end else if (bit_vld && m_cont != 0 && p < 3) begin
        if (my_addr[p] && line == 0) m_cont = 0;
        else if (p == 0) begin m_cont = 0; m_won = 1; end
      end
    end
  end

  // per-cycle comparison, mid low phase
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      check("R5 line_out vs model", int'(line_out), exp_line());
      check("R7 granted vs model", int'(granted), m_hold);
    end
  end

  task automatic frame();
    @(negedge clk); frame_start = 1'b1; bit_vld = 1'b0;
    @(negedge clk); frame_start = 1'b0;
    @(negedge clk);
    for (int b = 7; b >= 0; b--) begin
      @(negedge clk); bit_vld = 1'b1; bit_pos = 3'(b);
      #1 cap[b] = line_in;
    end
    @(negedge clk); bit_vld = 1'b0;
    #3;
  endtask

  initial begin
    #200000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    check("R1 reset granted", int'(granted), 0);
    check("R1 reset line_out", int'(line_out), 1);
    @(negedge clk); rst_n = 1'b1;

    // R2: disabled, request pending, bus free
    sw_req = 1'b1;
    repeat (3) frame();
    check("R2 disabled no grant", int'(granted), 0);
    check("R2 disabled byte released", int'(cap), 8'hFF);

    // R10: enabled, idle
    en = 1'b1; sw_req = 1'b0;
    frame();
    check("R10 idle address field", int'(cap[2:0]), 7);

    // R3/R7: software request wins with address 2
    my_addr = 3'd2; sw_req = 1'b1;
    frame();
    check("R7 no grant in win frame", int'(granted), 0);
    check("R5 address on line", int'(cap[2:0]), 2);
    frame();
    check("R7 grant next frame", int'(granted), 1);
    check("R7 status pulled low", int'(cap[5]), 0);
    sw_req = 1'b0; hdlc_req = 1'b1;
    frame();
    check("R3 hdlc request holds", int'(granted), 1);

    // R8/R9: release then immediate re-request
    hdlc_req = 1'b0;
    frame();
    check("R8 grant drops", int'(granted), 0);
    check("R8 status released", int'(cap[5]), 1);
    sw_req = 1'b1;
    frame();
    check("R9 backoff frame two", int'(cap[2:0]), 7);
    frame();
    check("R9 contend after two free", int'(cap[2:0]), 2);
    frame();
    check("R9 grant after backoff", int'(granted), 1);

    // R9: busy frame restarts count
    sw_req = 1'b0; frame();
    sw_req = 1'b1;
    ext_byte = 8'hDF; frame();
    ext_byte = 8'hFF; frame(); frame();
    check("R9 no contend after restart", int'(granted), 0);
    frame();
    check("R9 contend after restarted count", int'(cap[2:0]), 2);
    frame();
    check("R9 grant after restarted count", int'(granted), 1);

    // R2: disable while held
    @(negedge clk); en = 1'b0;
    @(negedge clk); #3;
    check("R2 disable drops grant", int'(granted), 0);
    en = 1'b1; sw_req = 1'b0;
    frame(); frame(); frame();

    // R4: busy status blocks contention
    sw_req = 1'b1; ext_byte = 8'hDF;
    frame();
    check("R4 busy no address", int'(cap[2:0]), 7);
    frame();
    check("R4 busy no grant", int'(granted), 0);

    // R6: address 5 loses to external 3
    my_addr = 3'd5; ext_byte = 8'hFB;
    frame();
    check("R6 lower address seen", int'(cap[2:0]), 3);
    frame();
    check("R6 loser no grant", int'(granted), 0);
    // R6: address 2 beats external 3
    my_addr = 3'd2;
    frame();
    check("R6 wired-AND result", int'(cap[2:0]), 2);
    frame();
    check("R6 lowest wins", int'(granted), 1);
    // R4: external device sees status 0 while held
    check("R4 held status busy", int'(cap[5]), 0);

    sw_req = 1'b0; ext_byte = 8'hFF;
    frame(); frame();
    check("R8 final release", int'(granted), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule